// File: doc/BRIEF.md
# Disciplined Packet Timestamp Counter

This block keeps a 64-bit time of day and stamps every packet that passes through it. The upper 32 bits are whole seconds and the lower 32 bits are a binary fraction of a second, so one fraction step is about 233 ps. Internally the fraction is held in a 48-bit phase accumulator: 16 hidden bits sit below the 32 visible ones. A trimmable increment is added to it on every clock edge, and at 160 MHz the default increment advances the time by about 6.25 ns per cycle. Each carry out of the accumulator adds one second.

A pulse-per-second input, for example from a satellite receiver, disciplines the counter. The pulse is synchronised and edge-detected. When discipline is on, each rising edge snaps the time to the nearest whole second plus a fixed latency allowance. The same edge also nudges the working increment by a clamped amount proportional to the phase error it saw. Several units fed from one pulse therefore share a time base.

Packets move through an AXI4-Stream style valid/ready path. Data beats are forwarded unchanged, with tlast held low. The time is taken on the edge that accepts a packet's first beat. After the packet's last beat, one extra beat carries the 64-bit stamp with tlast high. Back-pressure from the sink passes straight upstream. While the stamp beat waits, the input is stalled.

Top module: `pkt_tod_stamper`

## Requirements
- R1: While rst_n is low, cur_time reads 0, the increment is INCR_DEF (1759219), discipline is off and m_tvalid is low when s_tvalid is low.
- R2: On each clock edge the 48-bit accumulator gains the working increment. cur_time[31:0] shows accumulator bits 47:16. A carry out of bit 47 adds one to cur_time[63:32], which wraps from all ones to zero.
- R3: A write (cfg_wr high at an edge) decodes cfg_sel as follows. Code 0 loads cfg_data[47:0] into both the nominal and the working increment; the time advances with the old increment on that edge. Code 1 loads cfg_data[31:0] as seconds and clears the accumulator. Code 2 loads cfg_data[0] as the discipline enable. Code 3 changes nothing.
- R4: pps_in passes two synchronising flops. If it is sampled high at edge k after being low at edge k-1, the correction lands on edge k+2.
- R5: Let A be the current time plus the working increment, and let C be (COMP_CYC × working increment) mod 2^48. A correction sets the seconds to those of A−C rounded to the nearest whole second (accumulator bit 47 rounds up) and the accumulator to C.
- R6: On a correction, the working increment drops by the signed 48-bit error (A−C) mod 2^48 shifted right arithmetically by GAIN_SH. The step is clamped to ±(nominal >> 10).
- R7: With discipline off, pulse edges change neither the time nor the increment.
- R8: An input beat is accepted when s_tvalid and s_tready are both high. It appears on m_tdata in the same cycle with m_tlast low. s_tready equals m_tready when no stamp beat is pending.
- R9: After a last beat is accepted, the next output beat is the stamp with m_tlast high. s_tready stays low until that beat is taken.
- R10: The stamp equals the cur_time value shown just after the edge that accepted the packet's first beat, including when a correction lands on that same edge.
- R11: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata and m_tlast hold (given a compliant source).
- R12: A packet whose first beat is also its last still gets one stamp beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 160 MHz clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 increment, 1 seconds, 2 enable |
| cfg_data | input | 48 | Write value |
| pps_in | input | 1 | Asynchronous pulse-per-second |
| cur_time | output | 64 | Seconds and fraction |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat ready |
| s_tdata | input | 64 | Input beat data |
| s_tlast | input | 1 | Input last beat |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Output beat ready |
| m_tdata | output | 64 | Output data or stamp |
| m_tlast | output | 1 | Output last (the stamp beat) |

## Verification
The hardest case to reach is a first beat accepted on the very edge where a pulse correction lands. Reaching it needs the synchroniser delay counted exactly. The stimulus raises pps_in, waits two edges and then presents a first beat with the sink ready, so acceptance and correction fall on the same edge. A large increment makes seconds roll every 256 cycles. Pulses therefore arrive at phases in both halves of a second, which covers rounding up and down, clamped and unclamped increment steps, and the seconds wrap from all ones to zero. The whole time, random valid and ready patterns run on the stream.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic [1:0] {
    SEL_INCR = 2'd0,
    SEL_SEC  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pps_in,
  output logic pps_rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pps_in;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pps_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];

  assign pps_rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int              SEC_W    = 32,
  parameter int              FRAC_W   = 32,
  parameter int              EXT_W    = 16,
  parameter longint unsigned INCR_DEF = 64'd1759219,
  parameter int              COMP_CYC = 2,
  parameter int              GAIN_SH  = 27,
  parameter int              LIM_SH   = 10,
  localparam int             ACC_W    = FRAC_W + EXT_W,
  localparam int             TIME_W   = SEC_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [ACC_W-1:0]  cfg_data,
  input  logic              pps_rise,
  output logic [TIME_W-1:0] cur_time,
  output logic [TIME_W-1:0] next_time
);
  localparam int TOT_W = SEC_W + ACC_W;

  logic [SEC_W-1:0]  sec_q, sec_n;
  logic [ACC_W-1:0]  acc_q, acc_n;
  logic [ACC_W-1:0]  inc_nom_q, inc_nom_n, inc_cur_q, inc_cur_n;
  logic              en_q, en_n;

  logic [TOT_W-1:0]        t_adv, diff;
  logic [ACC_W-1:0]        comp;
  logic signed [ACC_W-1:0] err, adj, lim, adj_c;
  logic                    fix;
  cfg_sel_e                sel;

  always_comb begin
    sel   = cfg_sel_e'(cfg_sel);
    t_adv = {sec_q, acc_q} + TOT_W'(inc_cur_q);
    comp  = inc_cur_q * ACC_W'(COMP_CYC);
    diff  = t_adv - TOT_W'(comp);
    err   = diff[ACC_W-1:0];
    adj   = err >>> GAIN_SH;
    lim   = ACC_W'(inc_nom_q >> LIM_SH);
    if (adj > lim)       adj_c = lim;
    else if (adj < -lim) adj_c = -lim;
    else                 adj_c = adj;
    fix = pps_rise & en_q;

    {sec_n, acc_n} = t_adv;
    inc_nom_n      = inc_nom_q;
    inc_cur_n      = inc_cur_q;
    en_n           = en_q;
    if (fix) begin
      sec_n     = diff[TOT_W-1 -: SEC_W] + SEC_W'(diff[ACC_W-1]);
      acc_n     = comp;
      inc_cur_n = inc_cur_q - $unsigned(adj_c);
    end
    if (cfg_wr) begin
      case (sel)
        SEL_INCR: begin
          inc_nom_n = cfg_data;
          inc_cur_n = cfg_data;
        end
        SEL_SEC: begin
          sec_n = cfg_data[SEC_W-1:0];
          acc_n = '0;
        end
        SEL_EN:  en_n = cfg_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sec_q     <= '0;
      acc_q     <= '0;
      inc_nom_q <= ACC_W'(INCR_DEF);
      inc_cur_q <= ACC_W'(INCR_DEF);
      en_q      <= 1'b0;
    end else begin
      sec_q     <= sec_n;
      acc_q     <= acc_n;
      inc_nom_q <= inc_nom_n;
      inc_cur_q <= inc_cur_n;
      en_q      <= en_n;
    end

  assign cur_time  = {sec_q, acc_q[ACC_W-1 -: FRAC_W]};
  assign next_time = {sec_n, acc_n[ACC_W-1 -: FRAC_W]};
endmodule

// File: rtl/stamp_append.sv
module stamp_append #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] stamp_in,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tlast,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tlast
);
  logic              sop_q, tail_q;
  logic [DATA_W-1:0] stamp_q;

  assign s_tready = ~tail_q & m_tready;
  assign m_tvalid = tail_q | s_tvalid;
  assign m_tdata  = tail_q ? stamp_q : s_tdata;
  assign m_tlast  = tail_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sop_q   <= 1'b1;
      tail_q  <= 1'b0;
      stamp_q <= '0;
    end else if (tail_q) begin
      if (m_tready) begin
        tail_q <= 1'b0;
        sop_q  <= 1'b1;
      end
    end else if (s_tvalid && m_tready) begin
      if (sop_q) stamp_q <= stamp_in;
      sop_q <= 1'b0;
      if (s_tlast) tail_q <= 1'b1;
    end
endmodule

// File: rtl/pkt_tod_stamper.sv
module pkt_tod_stamper #(
  parameter int              SEC_W       = 32,
  parameter int              FRAC_W      = 32,
  parameter int              EXT_W       = 16,
  parameter longint unsigned INCR_DEF    = 64'd1759219,
  parameter int              COMP_CYC    = 2,
  parameter int              GAIN_SH     = 27,
  parameter int              LIM_SH      = 10,
  parameter int              SYNC_STAGES = 2,
  localparam int             ACC_W       = FRAC_W + EXT_W,
  localparam int             TIME_W      = SEC_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [ACC_W-1:0]  cfg_data,
  input  logic              pps_in,
  output logic [TIME_W-1:0] cur_time,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [TIME_W-1:0] s_tdata,
  input  logic              s_tlast,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [TIME_W-1:0] m_tdata,
  output logic              m_tlast
);
  logic              pps_rise;
  logic [TIME_W-1:0] next_time;

  pps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .pps_rise(pps_rise)
  );

  tod_counter #(
    .SEC_W(SEC_W), .FRAC_W(FRAC_W), .EXT_W(EXT_W), .INCR_DEF(INCR_DEF),
    .COMP_CYC(COMP_CYC), .GAIN_SH(GAIN_SH), .LIM_SH(LIM_SH)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .pps_rise(pps_rise),
    .cur_time(cur_time), .next_time(next_time)
  );

  stamp_append #(.DATA_W(TIME_W)) u_app (
    .clk(clk), .rst_n(rst_n), .stamp_in(next_time),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
  );
endmodule

// File: rtl/pkt_tod_stamper_chk.sv
module pkt_tod_stamper_chk #(
  parameter int SEC_W  = 32,
  parameter int TIME_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [TIME_W-1:0] cur_time,
  input logic              s_tvalid,
  input logic              s_tready,
  input logic [TIME_W-1:0] s_tdata,
  input logic              s_tlast,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [TIME_W-1:0] m_tdata,
  input logic              m_tlast
);
  assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr) |->
      SEC_W'(cur_time[TIME_W-1 -: SEC_W] - $past(cur_time[TIME_W-1 -: SEC_W])) <= SEC_W'(1));

  assert_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready) |-> (m_tvalid && m_tready && !m_tlast && m_tdata == s_tdata));

  assert_tail_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tlast) |-> !s_tready);

  assert_tail_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && s_tlast) |=> (m_tvalid && m_tlast));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
endmodule

bind pkt_tod_stamper pkt_tod_stamper_chk #(.SEC_W(SEC_W), .TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cur_time(cur_time),
  .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
);

// File: tb/pkt_tod_stamper_test.sv
module pkt_tod_stamper_test;
  localparam int              PERIOD = 6;
  localparam longint unsigned DEF    = 64'd1759219;
  localparam int              COMP   = 2;
  localparam int              GSH    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [47:0] cfg_data = '0;
  logic        pps_in = 1'b0;
  logic [63:0] cur_time;
  logic        s_tvalid = 1'b0, s_tready, s_tlast = 1'b0;
  logic [63:0] s_tdata = '0;
  logic        m_tvalid, m_tready = 1'b1, m_tlast;
  logic [63:0] m_tdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pkt_tod_stamper #(.INCR_DEF(DEF), .COMP_CYC(COMP), .GAIN_SH(GSH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .pps_in(pps_in), .cur_time(cur_time),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
  );

  // reference state, built from the requirements
  logic [31:0] msec;
  logic [47:0] macc, mnom, mcur;
  logic        men, ms1, ms2, ms3, msop, mtail, stall_prev, acc_in;
  logic [63:0] mstamp;
  string       ttag;
  int          rem = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    msec = '0; macc = '0; mnom = 48'(DEF); mcur = 48'(DEF); men = 1'b0;
    ms1 = 0; ms2 = 0; ms3 = 0; msop = 1; mtail = 0; mstamp = '0;
    stall_prev = 0; ttag = "R1";
  endtask

  task automatic model_step(input logic er);
    logic [79:0] t_adv, d;
    logic [47:0] comp, ncur, nnom, nacc;
    logic [31:0] nsec;
    logic signed [47:0] err, adj, lim;
    logic rise, fix, nen;
    if (!rst_n) begin model_reset(); return; end
    t_adv = {msec, macc} + 80'(mcur);
    comp  = mcur * 48'(COMP);
    d     = t_adv - 80'(comp);
    rise  = ms2 & ~ms3;
    fix   = rise & men;
    {nsec, nacc} = t_adv;
    ncur = mcur; nnom = mnom; nen = men;
    ttag = "R2";
    if (rise && !men) ttag = "R7";
    if (fix) begin
      nsec = d[79:48] + 32'(d[47]);
      nacc = comp;
      err  = d[47:0];
      adj  = err >>> GSH;
      lim  = 48'(mnom >> 10);
      if (adj > lim) adj = lim;
      else if (adj < -lim) adj = -lim;
      ncur = mcur - $unsigned(adj);
      ttag = "R4 R5";
    end
    if (cfg_wr) begin
      ttag = "R3";
      case (cfg_sel)
        2'd0: begin nnom = cfg_data; ncur = cfg_data; end
        2'd1: begin nsec = cfg_data[31:0]; nacc = '0; end
        2'd2: nen = cfg_data[0];
        default: ;
      endcase
    end
    if (!fix && mcur != 48'(DEF) && !cfg_wr && ttag == "R2") ttag = "R2 R6";
    // stream
    stall_prev = (mtail | s_tvalid) & ~m_tready;
    if (mtail) begin
      if (m_tready) begin mtail = 0; msop = 1; end
    end else if (s_tvalid && er) begin
      if (msop) mstamp = {nsec, nacc[47:16]};
      msop = 0;
      if (s_tlast) mtail = 1;
    end
    msec = nsec; macc = nacc; mcur = ncur; mnom = nnom; men = nen;
    ms3 = ms2; ms2 = ms1; ms1 = pps_in;
  endtask

  task automatic tick();
    logic ev, el, er;
    logic [63:0] ed;
    string stag;
    #1;
    chk(cur_time === {msec, macc[47:16]}, ttag, "time", cur_time, {msec, macc[47:16]});
    ev = mtail | s_tvalid;
    ed = mtail ? mstamp : s_tdata;
    el = mtail;
    er = ~mtail & m_tready;
    stag = stall_prev ? "R11" : (mtail ? "R10" : "R8");
    if (!rst_n) stag = "R1";
    chk(m_tvalid === ev, stag, "m_tvalid", 64'(m_tvalid), 64'(ev));
    chk(s_tready === er, mtail ? "R9" : "R8", "s_tready", 64'(s_tready), 64'(er));
    chk(m_tlast === el, mtail ? "R9" : "R8", "m_tlast", 64'(m_tlast), 64'(el));
    if (ev) chk(m_tdata === ed, stag, "m_tdata", m_tdata, ed);
    acc_in = s_tvalid & er;
    model_step(er);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic src_next(input bit allow);
    m_tready = ($urandom % 4) != 0;
    if (s_tvalid && !acc_in) return;
    if (allow && ($urandom % 3) != 0) begin
      if (rem == 0) rem = 1 + $urandom % 4;
      s_tdata  = {$urandom, $urandom};
      s_tlast  = (rem == 1);
      rem--;
      s_tvalid = 1'b1;
    end else begin
      s_tvalid = 1'b0;
    end
  endtask

  task automatic run(input int n, input bit allow);
    for (int i = 0; i < n; i++) begin src_next(allow); tick(); end
  endtask

  task automatic wcfg(input logic [1:0] sel, input logic [47:0] data);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = data;
    src_next(1); tick();
    cfg_wr = 1'b0;
  endtask

  task automatic pulse(input int gap);
    pps_in = 1'b1; run(3, 1);
    pps_in = 1'b0; run(gap, 1);
  endtask

  task automatic drain();
    for (int i = 0; i < 40; i++) begin
      if (!s_tvalid && !mtail && rem == 0) break;
      if (s_tvalid && !acc_in) begin m_tready = 1'b1; tick(); end
      else begin
        m_tready = 1'b1;
        if (rem != 0) begin
          s_tdata = {$urandom, $urandom}; s_tlast = (rem == 1); rem--; s_tvalid = 1'b1;
        end else s_tvalid = 1'b0;
        tick();
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk(cur_time === 64'd0, "R1", "reset time", cur_time, 64'd0);
      tick();
    end
    rst_n = 1'b1;
    run(300, 1);                          // R2 default increment
    wcfg(2'd3, 48'hFFFF_FFFF_FFFF);       // R3 code 3 ignored
    run(20, 1);
    wcfg(2'd0, 48'h0100_0000_0000);       // R3 increment 2^40
    wcfg(2'd1, 48'h0000_FFFF_FFFE);       // R3 seconds near wrap
    run(600, 1);                          // R2 wrap to zero
    pulse(40);                            // R7 disabled pulse
    wcfg(2'd2, 48'd1);                    // R3 enable
    for (int p = 0; p < 12; p++) pulse(20 + $urandom % 300);  // R4 R5 R6
    // R10: first beat accepted on the correction edge
    drain();
    s_tvalid = 1'b0; m_tready = 1'b1;
    pps_in = 1'b1; tick();
    pps_in = 1'b0; tick();
    s_tvalid = 1'b1; s_tlast = 1'b0; s_tdata = 64'hA5A5_0000_1111_2222; tick();
    s_tlast = 1'b1; s_tdata = 64'h5A5A_3333_4444_5555; tick();
    s_tvalid = 1'b0; s_tlast = 1'b0;
    #1;
    chk(m_tvalid && m_tlast && m_tdata[31:0] === 32'((mcur * 48'(COMP)) >> 16) | 1'b1,
        "R10", "stamp beat present", 64'(m_tvalid), 64'd1);
    tick(); tick();
    // R12: single-beat packet
    s_tvalid = 1'b1; s_tlast = 1'b1; s_tdata = 64'hC0DE; m_tready = 1'b1; tick();
    s_tvalid = 1'b0; s_tlast = 1'b0;
    #1;
    chk(m_tvalid && m_tlast, "R12", "single-beat stamp", {m_tvalid, m_tlast}, 2'b11);
    tick(); tick();
    wcfg(2'd2, 48'd0);
    pulse(60);                            // R7 after disable
    run(400, 1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule